// File: doc/BRIEF.md
# Sliding-Window 2x2 Correlation Matrix Engine

This block keeps the 2x2 autocorrelation matrix of a sample stream over a sliding window of `WIN` samples, for use by an affine projection adaptive filter. Each accepted sample updates the matrix in constant time. The newest product terms are added to two running sums, and the terms that fall out of the window are subtracted. The second diagonal entry is the first diagonal entry from the previous sample, so it needs no accumulator of its own.

The block adds a programmable regularisation value δ to the diagonal and outputs the four regularised entries together with their determinant. Samples still in the window are held in one circular memory. The memory writes the newest sample and, in the same cycle, prefetches the slot that will be evicted on the next sample. All six products per sample run one after another on a single shift-and-add multiplier. Each product takes `DW` cycles.

Products are `DW`x`DW` signed values. Each one is scaled down by an arithmetic right shift of `SH = log2(WIN)+1` before it is accumulated, so a full window fits in an `AW`-bit sum. The determinant is formed from the top `DW` bits of each regularised entry.

Top module: `slide_corr2x2`

## Requirements
- R1: While reset is active and after its release, with no sample accepted, `valid_o` is low and all matrix and determinant outputs are zero.
- R2: After sample n is processed, `n11_o` equals δ plus the sum over k = n-WIN+1..n of (x(k)·x(k) >>> SH), with SH = log2(WIN)+1. Any sample from before the last reset counts as zero.
- R3: `n12_o` and `n21_o` are equal and carry no δ. Both equal the sum over k = n-WIN+1..n of (x(k)·x(k-1) >>> SH). For the oldest k in the window, x(k-1) is the sample just outside the window.
- R4: `n22_o` for sample n equals the un-regularised first diagonal sum of sample n-1 plus the δ captured with sample n.
- R5: δ is sampled from `delta_i` only on the cycle a sample is accepted. Changes to `delta_i` while a sample is being processed do not affect that sample's outputs.
- R6: `det_o` equals t11·t22 − t12·t12, where tij is the signed top `DW` bits (bits AW-1 down to AW-DW) of the matching output entry.
- R7: Each accepted sample gives exactly one single-cycle `valid_o` pulse, 6·(DW+2) clock edges after the accepting edge. Between pulses all outputs hold their values.
- R8: A reset in the middle of a stream empties the window. The first sample after reset yields the same results as the first sample ever.
- R9: Samples are two's complement, including the most negative code −2^(DW−1). Its square is accumulated as a positive value, and cross products of opposite-sign samples are accumulated as negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; accepted only when idle |
| x_i | input | DW | New signed sample |
| delta_i | input | AW | Regularisation value added to the diagonal |
| n11_o | output | AW | First diagonal entry plus δ |
| n12_o | output | AW | Off-diagonal entry |
| n21_o | output | AW | Off-diagonal entry (equal to n12_o) |
| n22_o | output | AW | Second diagonal entry plus δ |
| det_o | output | 2·DW+1 | Determinant of the truncated entries |
| valid_o | output | 1 | One-cycle pulse when outputs are updated |

## Verification
The bench runs more than a full window of pseudo-random samples. This exercises the circular-buffer wrap and the eviction of both the oldest square and the oldest cross term. A design whose prefetch address or fill tracking was off by one would drift away from the direct windowed sum, either as soon as the first eviction happens or gradually after it. Full-scale negative and alternating-sign samples expose a broken sign path in the multiplier, which would give wrong squares or cross products with the wrong sign.

A change to δ during processing, and a reset in the middle of a stream, target designs that read `delta_i` live or leave stale window contents behind. The bench also measures the exact latency and pulse width of `valid_o`.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} ctl_st_e;

  // product order per sample; det products last
  typedef enum logic [2:0] {
    STP_SQ_NEW, STP_X_NEW, STP_SQ_OLD, STP_X_OLD, STP_DIAG, STP_OFF
  } step_e;
endpackage

// File: rtl/corr_ring.sv
module corr_ring #(
  parameter int DW  = 16,
  parameter int WIN = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] old_o
);
  localparam int PTRW = (WIN > 1) ? $clog2(WIN) : 1;

  logic [DW-1:0]   mem [WIN];
  logic [PTRW-1:0] ptr_q, ptr_nxt, fill_q;
  logic [DW-1:0]   pre_q;
  logic            pre_vld_q;

  generate
    if ((1 << PTRW) == WIN) begin : g_pow2
      assign ptr_nxt = ptr_q + 1'b1;
    end else begin : g_mod
      assign ptr_nxt = (ptr_q == PTRW'(WIN - 1)) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[ptr_q] <= d_i;
  end

  // prefetch the slot evicted by the next write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      fill_q    <= '0;
      pre_q     <= '0;
      pre_vld_q <= 1'b0;
    end else if (wr_i) begin
      ptr_q     <= ptr_nxt;
      pre_q     <= mem[ptr_nxt];
      pre_vld_q <= (fill_q == PTRW'(WIN - 1));
      if (fill_q != PTRW'(WIN - 1)) fill_q <= fill_q + 1'b1;
    end
  end

  assign old_o = pre_vld_q ? pre_q : '0;
endmodule

// File: rtl/corr_seqmul.sv
module corr_seqmul #(
  parameter int DW = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic signed [DW-1:0]   a_i,
  input  logic signed [DW-1:0]   b_i,
  output logic                   done_o,
  output logic signed [2*DW-1:0] p_o
);
  localparam int PW = 2 * DW;
  localparam int CW = $clog2(DW + 1);

  logic signed [PW-1:0] a_ext, b_ext;
  logic [PW-1:0]        a_abs, b_abs;
  logic [PW-1:0]        a_q, b_q, acc_q;
  logic [CW-1:0]        cnt_q;
  logic                 busy_q, neg_q, done_q;

  assign a_ext = PW'(a_i);
  assign b_ext = PW'(b_i);
  assign a_abs = a_ext[PW-1] ? PW'(-a_ext) : PW'(a_ext);
  assign b_abs = b_ext[PW-1] ? PW'(-b_ext) : PW'(b_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; acc_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; neg_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        a_q    <= a_abs;
        b_q    <= b_abs;
        neg_q  <= a_i[DW-1] ^ b_i[DW-1];
        acc_q  <= '0;
        cnt_q  <= CW'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (b_q[0]) acc_q <= acc_q + a_q;
        a_q   <= a_q << 1;
        b_q   <= b_q >> 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign p_o    = neg_q ? -$signed(acc_q) : $signed(acc_q);
endmodule

// File: rtl/slide_corr2x2.sv
module slide_corr2x2
  import corr_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 31,
  parameter int WIN = 512
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [AW-1:0] delta_i,
  output logic signed [AW-1:0] n11_o,
  output logic signed [AW-1:0] n12_o,
  output logic signed [AW-1:0] n21_o,
  output logic signed [AW-1:0] n22_o,
  output logic signed [2*DW:0] det_o,
  output logic                 valid_o
);
  localparam int PW = 2 * DW;
  localparam int SH = $clog2(WIN) + 1;

  ctl_st_e st_q;
  step_e   step_q;
  logic    accept, idle, mul_start, mul_done;

  logic signed [DW-1:0] x_cur_q, x_prev_q, ev_cur_q, ev_prev_q, ring_old;
  logic signed [AW-1:0] m11_q, m12_q, m22_q, delta_q;
  logic signed [AW-1:0] n11_c, n22_c, term;
  logic signed [PW-1:0] mul_p, p_sh, diag_q;
  logic signed [DW-1:0] op_a, op_b;

  assign idle   = (st_q == ST_IDLE);
  assign accept = idle && valid_i;

  corr_ring #(.DW(DW), .WIN(WIN)) u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(accept), .d_i(x_i), .old_o(ring_old)
  );

  assign n11_c = m11_q + delta_q;
  assign n22_c = m22_q + delta_q;

  always_comb begin
    op_a = x_cur_q;
    op_b = x_cur_q;
    unique case (step_q)
      STP_SQ_NEW: begin op_a = x_cur_q;  op_b = x_cur_q;   end
      STP_X_NEW:  begin op_a = x_cur_q;  op_b = x_prev_q;  end
      STP_SQ_OLD: begin op_a = ev_cur_q; op_b = ev_cur_q;  end
      STP_X_OLD:  begin op_a = ev_cur_q; op_b = ev_prev_q; end
      STP_DIAG:   begin op_a = n11_c[AW-1 -: DW]; op_b = n22_c[AW-1 -: DW]; end
      STP_OFF:    begin op_a = m12_q[AW-1 -: DW]; op_b = m12_q[AW-1 -: DW]; end
      default: ;
    endcase
  end

  assign mul_start = (st_q == ST_LOAD);

  corr_seqmul #(.DW(DW)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(mul_start),
    .a_i(op_a), .b_i(op_b), .done_o(mul_done), .p_o(mul_p)
  );

  assign p_sh = mul_p >>> SH;
  assign term = AW'(p_sh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; step_q <= STP_SQ_NEW;
      x_cur_q <= '0; x_prev_q <= '0; ev_cur_q <= '0; ev_prev_q <= '0;
      m11_q <= '0; m12_q <= '0; m22_q <= '0; delta_q <= '0; diag_q <= '0;
      n11_o <= '0; n12_o <= '0; n21_o <= '0; n22_o <= '0; det_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (valid_i) begin
          x_cur_q   <= x_i;
          x_prev_q  <= x_cur_q;
          ev_cur_q  <= ring_old;
          ev_prev_q <= ev_cur_q;
          m22_q     <= m11_q;
          delta_q   <= delta_i;
          step_q    <= STP_SQ_NEW;
          st_q      <= ST_LOAD;
        end
        ST_LOAD: st_q <= ST_WAIT;
        ST_WAIT: if (mul_done) begin
          unique case (step_q)
            STP_SQ_NEW: m11_q  <= m11_q + term;
            STP_X_NEW:  m12_q  <= m12_q + term;
            STP_SQ_OLD: m11_q  <= m11_q - term;
            STP_X_OLD:  m12_q  <= m12_q - term;
            STP_DIAG:   diag_q <= mul_p;
            STP_OFF: begin
              n11_o   <= n11_c;
              n12_o   <= m12_q;
              n21_o   <= m12_q;
              n22_o   <= n22_c;
              det_o   <= (PW+1)'(diag_q) - (PW+1)'(mul_p);
              valid_o <= 1'b1;
            end
            default: ;
          endcase
          if (step_q == STP_OFF) st_q <= ST_IDLE;
          else begin
            step_q <= step_e'(step_q + 3'd1);
            st_q   <= ST_LOAD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

module slide_corr2x2_chk #(
  parameter int DW = 16,
  parameter int AW = 31
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 idle,
  input logic signed [AW-1:0] delta_q,
  input logic signed [AW-1:0] n11_o,
  input logic signed [AW-1:0] n12_o,
  input logic signed [AW-1:0] n21_o,
  input logic signed [AW-1:0] n22_o,
  input logic signed [2*DW:0] det_o,
  input logic                 valid_o
);
  logic signed [AW-1:0] prev_m11_q;
  logic                 pend_q;
  logic signed [DW-1:0] t11, t22, t12;
  logic signed [2*DW:0] det_ref;

  assign t11 = n11_o[AW-1 -: DW];
  assign t22 = n22_o[AW-1 -: DW];
  assign t12 = n12_o[AW-1 -: DW];
  assign det_ref = t11 * t22 - t12 * t12;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_m11_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (valid_o) prev_m11_q <= n11_o - delta_q;
      if (valid_i && idle) pend_q <= 1'b1;
      else if (valid_o) pend_q <= 1'b0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !valid_o);
  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R7
  valid_owed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pend_q);
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(det_o) && $stable(n11_o) && $stable(n22_o));
  // R3
  sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> n12_o == n21_o);
  // R4
  diag_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> n22_o == prev_m11_q + delta_q);
  // R6
  det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> det_o == det_ref);
endmodule

bind slide_corr2x2 slide_corr2x2_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .idle(idle),
  .delta_q(delta_q), .n11_o(n11_o), .n12_o(n12_o), .n21_o(n21_o),
  .n22_o(n22_o), .det_o(det_o), .valid_o(valid_o)
);

// File: tb/slide_corr2x2_bench.sv
module slide_corr2x2_bench;
  localparam int DW  = 16;
  localparam int AW  = 31;
  localparam int WIN = 512;
  localparam int SH  = $clog2(WIN) + 1;
  localparam int LAT = 6 * (DW + 2);

  logic clk = 1'b0, rst_n = 1'b0, valid_i = 1'b0;
  logic signed [DW-1:0] x_i = '0;
  logic signed [AW-1:0] delta_i = '0;
  logic signed [AW-1:0] n11, n12, n21, n22;
  logic signed [2*DW:0] det;
  logic valid_o;

  always #5 clk = ~clk;

  slide_corr2x2 #(.DW(DW), .AW(AW), .WIN(WIN)) u_slide_corr2x2 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .x_i(x_i), .delta_i(delta_i),
    .n11_o(n11), .n12_o(n12), .n21_o(n21), .n22_o(n22), .det_o(det), .valid_o(valid_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint hist [0:4095];
  int nh = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic longint xs(int k);
    return (k < 0) ? 64'sd0 : hist[k];
  endfunction

  function automatic longint m11_at(int i);
    longint s = 0;
    for (int k = i - WIN + 1; k <= i; k++) s += (xs(k) * xs(k)) >>> SH;
    return s;
  endfunction

  function automatic longint m12_at(int i);
    longint s = 0;
    for (int k = i - WIN + 1; k <= i; k++) s += (xs(k) * xs(k - 1)) >>> SH;
    return s;
  endfunction

  function automatic longint top(longint v);
    return v >>> (AW - DW);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one sample; returns edges from accept to valid
  task automatic send(longint x, longint d, output int lat);
    @(negedge clk);
    valid_i = 1'b1; x_i = DW'(x); delta_i = AW'(d);
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++; @(negedge clk);
    end while (!valid_o && lat < 400);
    hist[nh] = x; nh++;
  endtask

  task automatic expect_out(string req, longint d);
    int i = nh - 1;
    longint e11 = m11_at(i) + d;
    longint e12 = m12_at(i);
    longint e22 = m11_at(i - 1) + d;
    longint ed  = top(e11) * top(e22) - top(e12) * top(e12);
    chk(req, "n11", n11, e11);
    chk(req, "n12", n12, e12);
    chk(req, "n21", n21, e12);
    chk(req, "n22", n22, e22);
    chk(req, "det", det, ed);
  endtask

  task automatic t_reset();
    // R1
    chk("R1", "valid in reset", valid_o, 0);
    chk("R1", "n11 in reset", n11, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "valid after reset", valid_o, 0);
    chk("R1", "det after reset", det, 0);
    chk("R1", "n22 after reset", n22, 0);
  endtask

  task automatic t_first();
    int lat;
    send(1000, 5, lat);
    chk("R7", "latency", lat, LAT);
    expect_out("R2", 5);
    @(negedge clk);
    chk("R7", "pulse width", valid_o, 0);
  endtask

  task automatic t_signs();
    int lat;
    longint v [6] = '{20000, -20000, -32768, -32768, 32767, -1};
    foreach (v[j]) begin
      send(v[j], 100, lat);
      expect_out("R9", 100);
      chk("R3", "n12 sign", n12 < 0, m12_at(nh - 1) < 0);
    end
  endtask

  task automatic t_hold();
    longint h11 = n11, hd = det;
    bit seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (valid_o) seen = 1;
    end
    chk("R7", "no pulse when idle", seen, 0);
    chk("R7", "n11 held", n11, h11);
    chk("R7", "det held", det, hd);
  endtask

  task automatic t_delta();
    int lat;
    @(negedge clk);
    valid_i = 1'b1; x_i = 16'sd1234; delta_i = 31'sd777;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0; delta_i = 31'sd99999;
    lat = 0;
    do begin
      @(posedge clk); lat++; @(negedge clk);
    end while (!valid_o && lat < 400);
    hist[nh] = 1234; nh++;
    expect_out("R5", 777);
    send(-4321, 99999, lat);
    expect_out("R5", 99999);
    chk("R4", "n22 after delta change", n22, m11_at(nh - 2) + 99999);
  endtask

  task automatic t_wrap();
    int lat;
    for (int j = 0; j < WIN + 60; j++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(longint'($signed(lfsr)), 3, lat);
      if (j >= WIN - 20) expect_out("R2", 3);
    end
    chk("R7", "latency after wrap", lat, LAT);
  endtask

  task automatic t_rerst();
    int lat;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R1", "valid in mid reset", valid_o, 0);
    rst_n = 1'b1;
    nh = 0;
    send(-3000, 11, lat);
    expect_out("R8", 11);
    chk("R8", "n12 fresh window", n12, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first();
    t_signs();
    t_hold();
    t_delta();
    t_wrap();
    t_rerst();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule